// File: doc/BRIEF.md
# Bit-Serial Symmetric FIR Filter with Distributed Arithmetic

This block is a linear-phase FIR filter that computes its output without any multiplier. Each new sample enters a delay line of parallel words, one word per tap. The words are then shifted out one bit per clock, least significant bit first, and bit-serial adders fold each pair of mirror taps into a single bit stream. The bits from all pairs form an address into a small table of precomputed coefficient sums. An accumulator adds each table word to half of its running value, and on the sign-bit cycle it subtracts the table word instead.

A sample is offered with a one-cycle strobe. After a fixed latency the filtered word appears with a one-cycle valid pulse and is held until the next result. A word of `SAMPLE_W` bits occupies the engine for `SAMPLE_W+1` clocks, whatever the tap count. Holding the strobe high streams one sample per word period. The coefficients are supplied as a parameter vector and only the first half of the symmetric set is given.

Top module: `da_sym_fir`

## Requirements
- R1: While `rst` is high and in the cycle after it, `dout` is 0 and `dout_vld` is 0. The delay line is cleared, so the first result after reset reflects only the samples accepted since then.
- R2: For accepted samples x[0] (newest) to x[TAPS-1], `dout` equals floor(sum c[j]*x[j] / 2^SAMPLE_W), in two's complement and `AW` bits wide. The coefficient set is symmetric, c[j] = c[TAPS-1-j]. The value c[j] for j < TAPS/2 is the signed field `COEFS[j*COEF_W +: COEF_W]`.
- R3: A strobe accepted at clock edge E raises `dout_vld` for exactly the one cycle that follows edge E+SAMPLE_W+1. Two valid pulses are never closer than SAMPLE_W+1 cycles.
- R4: Samples are two's complement. All taps at the most positive value, all taps at the most negative value, and alternating extremes give exact results with no overflow.
- R5: A strobe held high continuously is accepted once every SAMPLE_W+1 cycles, on the idle cycle or on the last bit cycle of the current word, and every accepted word produces a correct result.
- R6: A strobe that arrives while a word is in progress, and not on its last bit cycle, is ignored. It produces no extra valid pulse, does not restart the word, and does not enter the delay line.
- R7: `dout` keeps its value in every cycle in which `dout_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din_stb | input | 1 | Sample strobe; taken when the engine is idle or on its last bit cycle |
| din | input | SAMPLE_W | Signed input sample |
| dout_vld | output | 1 | One-cycle pulse marking a new result |
| dout | output | AW | Signed filter output, the upper part of the accumulated sum |

## Verification
The assertions check, on every cycle, the shape of the valid pulse and its minimum spacing, that the output holds between pulses, the range of the bit counter, and that a strobe during a busy word only advances the counter. These rules depend on neither the sample values nor the coefficients. Whether the result is numerically correct can be shown only by the bench scenarios. Those scenarios cover an impulse walked through every tap, full-scale positive and negative words that exercise the sign-cycle subtraction and the carry clearing, continuous streaming, and strobes injected in the middle of a word. Each is compared against a behavioural sum-of-products model on every clock.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // width that holds any signed sum of 'pairs' coefficients
    function automatic int lut_width(input int pairs, input int coef_w);
        return coef_w + $clog2(pairs) + 1;
    endfunction

    // width of a counter that reaches sample_w
    function automatic int cnt_width(input int sample_w);
        return $clog2(sample_w + 1);
    endfunction

endpackage

// File: rtl/da_skew_p2s.sv
module da_skew_p2s #(
    parameter int TAPS     = 10,
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] din,
    output logic [TAPS-1:0]     tap_bits
);
    // parallel delay line of sample words
    logic [SAMPLE_W-1:0] hist [TAPS];
    // per-tap serialisers, arithmetic shift keeps the sign on top
    logic [SAMPLE_W-1:0] ser  [TAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS; i++) begin
                hist[i] <= '0;
                ser[i]  <= '0;
            end
        end else if (load) begin
            hist[0] <= din;
            ser[0]  <= din;
            for (int i = 1; i < TAPS; i++) begin
                hist[i] <= hist[i-1];
                ser[i]  <= hist[i-1];
            end
        end else begin
            for (int i = 0; i < TAPS; i++) begin
                ser[i] <= {ser[i][SAMPLE_W-1], ser[i][SAMPLE_W-1:1]};
            end
        end
    end

    for (genvar t = 0; t < TAPS; t++) begin : g_bit
        assign tap_bits[t] = ser[t][0];
    end

endmodule

// File: rtl/da_pair_add.sv
module da_pair_add #(
    parameter int PAIRS = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [PAIRS-1:0] a,
    input  logic [PAIRS-1:0] b,
    output logic [PAIRS-1:0] sum
);
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        logic carry_q;
        logic cin;

        assign cin    = clr ? 1'b0 : carry_q;
        assign sum[p] = a[p] ^ b[p] ^ cin;

        always_ff @(posedge clk) begin
            if (rst) begin
                carry_q <= 1'b0;
            end else begin
                carry_q <= (a[p] & b[p]) | (cin & (a[p] ^ b[p]));
            end
        end
    end

endmodule

// File: rtl/da_coef_lut.sv
module da_coef_lut #(
    parameter int                       PAIRS  = 5,
    parameter int                       COEF_W = 10,
    parameter int                       LUT_W  = 14,
    parameter logic [PAIRS*COEF_W-1:0]  COEFS  = '0
) (
    input  logic [PAIRS-1:0]        addr,
    output logic signed [LUT_W-1:0] value
);
    localparam int DEPTH = 1 << PAIRS;

    logic signed [LUT_W-1:0] entries [DEPTH];

    // entry k: sum of the coefficients whose pair bit is set in k
    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            entries[k] = '0;
            for (int j = 0; j < PAIRS; j++) begin
                if (((k >> j) & 1) != 0) begin
                    entries[k] = entries[k]
                               + LUT_W'($signed(COEFS[j*COEF_W +: COEF_W]));
                end
            end
        end
    end

    assign value = entries[addr];

endmodule

// File: rtl/da_scale_acc.sv
module da_scale_acc #(
    parameter int LUT_W = 14,
    parameter int AW    = 15
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step,
    input  logic                    first,
    input  logic                    last,
    input  logic signed [LUT_W-1:0] lut_val,
    output logic                    dout_vld,
    output logic [AW-1:0]           dout
);
    logic signed [AW-1:0] acc_q;
    logic signed [AW-1:0] lut_ext;
    logic signed [AW-1:0] halved;
    logic        [AW-1:0] term;
    logic        [AW-1:0] acc_nxt;

    assign lut_ext = AW'(lut_val);
    assign halved  = acc_q >>> 1;
    assign term    = last ? ~lut_ext : lut_ext;

    always_comb begin
        if (first) begin
            acc_nxt = lut_ext;
        end else begin
            acc_nxt = halved + term + {{(AW-1){1'b0}}, last};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= step & last;
            if (step) begin
                acc_q <= acc_nxt;
            end
            if (step && last) begin
                dout <= acc_nxt;
            end
        end
    end

endmodule

// File: rtl/da_sym_fir.sv
module da_sym_fir
    import da_fir_pkg::*;
#(
    parameter int                             TAPS     = 10,
    parameter int                             SAMPLE_W = 10,
    parameter int                             COEF_W   = 10,
    parameter logic [(TAPS/2)*COEF_W-1:0]     COEFS    =
        {10'sd255, 10'sd190, 10'sd85, -10'sd40, 10'sd12},
    parameter int                             AW       =
        lut_width(TAPS/2, COEF_W) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                din_stb,
    input  logic [SAMPLE_W-1:0] din,
    output logic                dout_vld,
    output logic [AW-1:0]       dout
);
    localparam int PAIRS = TAPS / 2;
    localparam int LUT_W = lut_width(PAIRS, COEF_W);
    localparam int CNTW  = cnt_width(SAMPLE_W);
    localparam logic [CNTW-1:0] LAST_CNT = CNTW'(SAMPLE_W);

    phase_e          phase;
    logic [CNTW-1:0] bit_cnt;
    logic            busy;
    logic            first_bit;
    logic            last_bit;
    logic            accept;

    logic [TAPS-1:0]         tap_bits;
    logic [PAIRS-1:0]        near_bits;
    logic [PAIRS-1:0]        far_bits;
    logic [PAIRS-1:0]        lut_addr;
    logic signed [LUT_W-1:0] lut_val;

    assign busy      = (phase == PH_RUN);
    assign first_bit = busy && (bit_cnt == '0);
    assign last_bit  = busy && (bit_cnt == LAST_CNT);
    assign accept    = din_stb && (!busy || last_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
        end else if (accept) begin
            phase   <= PH_RUN;
            bit_cnt <= '0;
        end else if (last_bit) begin
            phase   <= PH_IDLE;
        end else if (busy) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    da_skew_p2s #(
        .TAPS     (TAPS),
        .SAMPLE_W (SAMPLE_W)
    ) u_skew (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .din      (din),
        .tap_bits (tap_bits)
    );

    for (genvar p = 0; p < PAIRS; p++) begin : g_fold
        assign near_bits[p] = tap_bits[p];
        assign far_bits[p]  = tap_bits[TAPS-1-p];
    end

    da_pair_add #(
        .PAIRS (PAIRS)
    ) u_pairs (
        .clk (clk),
        .rst (rst),
        .clr (first_bit),
        .a   (near_bits),
        .b   (far_bits),
        .sum (lut_addr)
    );

    da_coef_lut #(
        .PAIRS  (PAIRS),
        .COEF_W (COEF_W),
        .LUT_W  (LUT_W),
        .COEFS  (COEFS)
    ) u_lut (
        .addr  (lut_addr),
        .value (lut_val)
    );

    da_scale_acc #(
        .LUT_W (LUT_W),
        .AW    (AW)
    ) u_acc (
        .clk      (clk),
        .rst      (rst),
        .step     (busy),
        .first    (first_bit),
        .last     (last_bit),
        .lut_val  (lut_val),
        .dout_vld (dout_vld),
        .dout     (dout)
    );

endmodule

// File: rtl/da_sym_fir_chk.sv
module da_sym_fir_chk #(
    parameter int SAMPLE_W = 10,
    parameter int AW       = 15,
    parameter int CNTW     = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            din_stb,
    input logic            busy,
    input logic [CNTW-1:0] cnt,
    input logic            dout_vld,
    input logic [AW-1:0]   dout
);
    localparam int              GAP      = SAMPLE_W + 1;
    localparam logic [CNTW-1:0] LAST_CNT = CNTW'(SAMPLE_W);

    logic [CNTW:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= (CNTW+1)'(GAP);
        end else if (dout_vld) begin
            gap_q <= (CNTW+1)'(1);
        end else if (gap_q < (CNTW+1)'(GAP)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!dout_vld && dout == '0));

    // R3
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dout_vld |=> !dout_vld);

    // R3
    vld_gap_chk: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> gap_q == (CNTW+1)'(GAP));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt <= LAST_CNT);

    // R6
    busy_strobe_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != LAST_CNT && din_stb) |=>
            (busy && cnt == CNTW'($past(cnt) + 1'b1)));

    // R7
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_vld |-> $stable(dout));

endmodule

bind da_sym_fir da_sym_fir_chk #(
    .SAMPLE_W (SAMPLE_W),
    .AW       (AW),
    .CNTW     (CNTW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .din_stb  (din_stb),
    .busy     (busy),
    .cnt      (bit_cnt),
    .dout_vld (dout_vld),
    .dout     (dout)
);

// File: tb/da_sym_fir_test.sv
module da_sym_fir_test;
    localparam int TAPS     = 10;
    localparam int SAMPLE_W = 10;
    localparam int PAIRS    = TAPS / 2;
    localparam int AW       = da_fir_pkg::lut_width(PAIRS, 10) + 1;
    localparam int WORD     = SAMPLE_W + 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                din_stb = 1'b0;
    logic [SAMPLE_W-1:0] din = '0;
    logic                dout_vld;
    logic [AW-1:0]       dout;

    always #5 clk = ~clk;

    da_sym_fir uut (
        .clk      (clk),
        .rst      (rst),
        .din_stb  (din_stb),
        .din      (din),
        .dout_vld (dout_vld),
        .dout     (dout)
    );

    int    cf [PAIRS] = '{12, -40, 85, 190, 255};
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;
    string cur_tag = "R1";

    // behavioural reference: sample history and word timing
    int hq [$];
    bit m_busy = 1'b0;
    int m_cnt  = 0;
    bit m_vld  = 1'b0;
    int m_dout = 0;
    int m_pend = 0;

    function automatic int coef_of(input int j);
        return (j < PAIRS) ? cf[j] : cf[TAPS-1-j];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0; m_cnt = 0; m_vld = 1'b0; m_dout = 0;
            hq.delete();
        end else begin
            bit take;
            int y;
            take  = din_stb && (!m_busy || m_cnt == SAMPLE_W);
            m_vld = 1'b0;
            if (m_busy) begin
                if (m_cnt == SAMPLE_W) begin
                    m_vld = 1'b1; m_dout = m_pend; m_busy = 1'b0;
                end else begin
                    m_cnt++;
                end
            end
            if (take) begin
                hq.push_front(int'($signed(din)));
                if (hq.size() > TAPS) void'(hq.pop_back());
                y = 0;
                for (int j = 0; j < hq.size(); j++) y += coef_of(j) * hq[j];
                m_pend = y >>> SAMPLE_W;
                m_busy = 1'b1; m_cnt = 0;
            end
        end
    end

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 valid timing", dout_vld == m_vld, int'(dout_vld), int'(m_vld));
            chk(dout_vld ? cur_tag : "R7 hold", int'($signed(dout)) == m_dout,
                int'($signed(dout)), m_dout);
        end
    end

    task automatic send(input int v, input int idle);
        @(negedge clk);
        din = SAMPLE_W'(v); din_stb = 1'b1;
        @(negedge clk);
        din_stb = 1'b0;
        repeat (idle) @(negedge clk);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset dout", dout == '0, int'(dout), 0);
        chk("R1 reset valid", dout_vld == 1'b0, int'(dout_vld), 0);
        rst = 1'b0;

        // R1: first word after reset sees an empty delay line
        cur_tag = "R1 first word";
        send(100, WORD + 2);

        // R2: impulse through every tap
        cur_tag = "R2 impulse";
        send(511, WORD + 2);
        for (int i = 0; i < TAPS; i++) send(0, WORD + 1);
        send(-300, WORD);
        for (int i = 0; i < TAPS; i++) send(0, WORD);

        // R4: full-scale extremes
        cur_tag = "R4 extremes";
        for (int i = 0; i < TAPS; i++) send(511, WORD);
        for (int i = 0; i < TAPS; i++) send(-512, WORD);
        for (int i = 0; i < 2*TAPS; i++) send((i % 2) ? -512 : 511, WORD);

        // R5: strobe held high, new data every cycle
        cur_tag = "R5 streaming";
        @(negedge clk);
        din_stb = 1'b1;
        for (int c = 0; c < 24*WORD; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            din  = lfsr[SAMPLE_W-1:0];
            @(negedge clk);
        end
        din_stb = 1'b0;
        repeat (2*WORD) @(negedge clk);

        // R6: strobes in the middle of a word are ignored
        cur_tag = "R6 mid-word strobe";
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            din = SAMPLE_W'(37 * i - 90); din_stb = 1'b1;
            @(negedge clk);
            din_stb = 1'b0;
            repeat (2 + i) @(negedge clk);
            din = SAMPLE_W'(-511); din_stb = 1'b1;
            @(negedge clk);
            din_stb = 1'b0;
            repeat (WORD + 2) @(negedge clk);
        end

        repeat (2*WORD) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule